// File: doc/BRIEF.md
# Nibble Compare and Bit-Test Unit

This unit carries out the compare and memory bit instructions of a small 4-bit controller core. A decoder hands it a 10-bit instruction word with a one-cycle `start` strobe. The decoder also passes a flag saying whether a second word follows, and the RAM address field of that second word. The unit captures the A, B and Y nibbles and the external RAM pointer in the same cycle. It then reads one nibble from RAM, and it either produces a status bit or writes back a nibble with one bit changed.

Compare results, bit-test results and the outcome of the less-or-equal forms all go to one status flag. Its meaning depends on the instruction. For not-equal forms it means "operands differ". For less-or-equal forms it means "no borrow". For a bit test it is the tested bit. Forms that take their RAM address from the second word spend one extra cycle before they execute. The unit reports the cycle count of each accepted instruction.

Top module: `nibble_cmp_unit`

## Requirements
- R1: While reset is active, and after it is released with no instruction accepted, `statusFlag`, `ramWrEn` and `execPulse` are 0 and `cycleCount` is 0.
- R2: Not-equal forms set status to 1 exactly when the two operands differ. The forms are A vs M (`0000000100`), B vs M (`0001000100`), immediate vs M (`000010iiii`) and Y vs immediate (`000111iiii`). The immediate is bits 3:0.
- R3: Less-or-equal forms set status to 1 exactly when the left operand is unsigned less than or equal to the right operand, so equal operands give 1. The forms are A vs M (`0000010100`), B vs M (`0011000100`), immediate vs M (`000011iiii`) and A vs immediate (`101011iiii`).
- R4: Bit set (`00100001nn`) and bit clear (`00100010nn`) write M back with bit nn forced to 1 or 0. Bit 0 is the least significant bit. All other bits keep their value, and status is left unchanged.
- R5: Bit test (`00100011nn`) copies bit nn of M into status and performs no RAM write.
- R6: `start` is accepted only when the unit is idle. For a one-word form, `execPulse` is high for exactly the cycle after the accepting edge. RAM is addressed and written in that cycle, and status changes at the edge that ends it.
- R7: When `hasSecond` is 1 for a memory form (immediate/A not-equal, A/immediate less-or-equal, bit set, clear, test), the RAM address is `directAddr`. Execution is delayed by one cycle.
- R8: `hasSecond` has no effect on the B-vs-M, Y-vs-immediate and A-vs-immediate forms. These take one cycle and use `ramPtr`.
- R9: From the accepting edge on, `cycleCount` shows 2 for a direct form and 1 for every other word. It holds that value until the next acceptance.
- R10: A `start` asserted while an instruction is in progress is ignored.
- R11: A word matching no listed encoding still produces one `execPulse` cycle. It causes no RAM write and leaves status unchanged.
- R12: Operands, pointer and direct address are sampled at the accepting edge. Later changes to these inputs do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction valid strobe |
| instrWord | input | 10 | Decoded instruction word |
| hasSecond | input | 1 | A second word with a RAM address accompanies the instruction |
| directAddr | input | ADDR_W | RAM address field of the second word |
| regA | input | 4 | Accumulator nibble |
| regB | input | 4 | B register nibble |
| regY | input | 4 | Y register nibble |
| ramPtr | input | ADDR_W | External RAM pointer for one-word forms |
| ramAddr | output | ADDR_W | RAM address |
| ramRdData | input | 4 | RAM read data (combinational read) |
| ramWrData | output | 4 | RAM write data |
| ramWrEn | output | 1 | RAM write enable |
| statusFlag | output | 1 | Shared status result |
| cycleCount | output | 2 | Cycle count of the last accepted instruction |
| execPulse | output | 1 | High in the execute cycle |

## Verification
The bench builds the unit with the default `ADDR_W` of 4, so pointer and direct address each span all 16 nibbles of the bench RAM model. Direct and pointer addresses are drawn independently, so a wrong address selection hits a different nibble and shows up in the status or the written data. The 4-bit nibble width lets directed cases reach the unsigned extremes 0 and 15 and all four bit positions.

// File: rtl/nibcmp_pkg.sv
package nibcmp_pkg;
  localparam int NIB_W = 4;
  localparam int IW    = 10;
  localparam int BIT_W = $clog2(NIB_W);

  // full-word encodings
  localparam logic [IW-1:0] ENC_A_NE_M = 10'b0000000100;
  localparam logic [IW-1:0] ENC_B_NE_M = 10'b0001000100;
  localparam logic [IW-1:0] ENC_A_LE_M = 10'b0000010100;
  localparam logic [IW-1:0] ENC_B_LE_M = 10'b0011000100;
  // six-bit prefixes followed by an immediate
  localparam logic [5:0] PFX_I_NE_M = 6'b000010;
  localparam logic [5:0] PFX_Y_NE_I = 6'b000111;
  localparam logic [5:0] PFX_I_LE_M = 6'b000011;
  localparam logic [5:0] PFX_A_LE_I = 6'b101011;
  // eight-bit prefixes followed by a bit index
  localparam logic [7:0] PFX_BSET = 8'b00100001;
  localparam logic [7:0] PFX_BCLR = 8'b00100010;
  localparam logic [7:0] PFX_BTST = 8'b00100011;

  typedef enum logic [2:0] {K_NOP, K_NE, K_LE, K_SET, K_CLR, K_TEST} kind_e;
  typedef enum logic [1:0] {L_A, L_B, L_Y, L_IMM} lhs_e;

  typedef struct packed {
    logic  latchEn;
    logic  execEn;
    kind_e kind;
    lhs_e  lhsSel;
    logic  rhsMem;
    logic  useDirect;
  } ctrl_t;
endpackage

// File: rtl/nibcmp_ctrl.sv
module nibcmp_ctrl
  import nibcmp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] instrWord,
  input  logic          hasSecond,
  output ctrl_t         strobes,
  output logic [1:0]    cycleCount
);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_EXEC} state_e;

  state_e state;
  kind_e  kindQ, dKind;
  lhs_e   lhsQ, dLhs;
  logic   rhsMemQ, dRhsMem;
  logic   directQ, dDirOk;
  logic   accept;

  assign accept = start && (state == ST_IDLE);

  always_comb begin
    dKind   = K_NOP;
    dLhs    = L_A;
    dRhsMem = 1'b1;
    dDirOk  = 1'b0;
    if (instrWord == ENC_A_NE_M) begin
      dKind = K_NE; dDirOk = 1'b1;
    end else if (instrWord == ENC_B_NE_M) begin
      dKind = K_NE; dLhs = L_B;
    end else if (instrWord[9:4] == PFX_I_NE_M) begin
      dKind = K_NE; dLhs = L_IMM; dDirOk = 1'b1;
    end else if (instrWord[9:4] == PFX_Y_NE_I) begin
      dKind = K_NE; dLhs = L_Y; dRhsMem = 1'b0;
    end else if (instrWord == ENC_A_LE_M) begin
      dKind = K_LE; dDirOk = 1'b1;
    end else if (instrWord == ENC_B_LE_M) begin
      dKind = K_LE; dLhs = L_B;
    end else if (instrWord[9:4] == PFX_I_LE_M) begin
      dKind = K_LE; dLhs = L_IMM; dDirOk = 1'b1;
    end else if (instrWord[9:4] == PFX_A_LE_I) begin
      dKind = K_LE; dRhsMem = 1'b0;
    end else if (instrWord[9:2] == PFX_BSET) begin
      dKind = K_SET; dDirOk = 1'b1;
    end else if (instrWord[9:2] == PFX_BCLR) begin
      dKind = K_CLR; dDirOk = 1'b1;
    end else if (instrWord[9:2] == PFX_BTST) begin
      dKind = K_TEST; dDirOk = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      kindQ      <= K_NOP;
      lhsQ       <= L_A;
      rhsMemQ    <= 1'b0;
      directQ    <= 1'b0;
      cycleCount <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= (hasSecond && dDirOk) ? ST_ADDR : ST_EXEC;
        ST_ADDR: state <= ST_EXEC;
        default: state <= ST_IDLE;
      endcase
      if (accept) begin
        kindQ      <= dKind;
        lhsQ       <= dLhs;
        rhsMemQ    <= dRhsMem;
        directQ    <= hasSecond && dDirOk;
        cycleCount <= (hasSecond && dDirOk) ? 2'd2 : 2'd1;
      end
    end
  end

  always_comb begin
    strobes.latchEn   = accept;
    strobes.execEn    = (state == ST_EXEC);
    strobes.kind      = kindQ;
    strobes.lhsSel    = lhsQ;
    strobes.rhsMem    = rhsMemQ;
    strobes.useDirect = directQ;
  end

  // R6
  exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.execEn |=> !strobes.execEn);

  // R7
  addr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR) |=> strobes.execEn && (cycleCount == 2'd2));

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.execEn |-> (cycleCount == 2'd1 || cycleCount == 2'd2));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> $stable(kindQ) || (state != ST_EXEC));
endmodule

// File: rtl/nibcmp_dp.sv
module nibcmp_dp
  import nibcmp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             strobes,
  input  logic [NIB_W-1:0]  immField,
  input  logic [ADDR_W-1:0] directAddr,
  input  logic [NIB_W-1:0]  regA,
  input  logic [NIB_W-1:0]  regB,
  input  logic [NIB_W-1:0]  regY,
  input  logic [ADDR_W-1:0] ramPtr,
  input  logic [NIB_W-1:0]  ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [NIB_W-1:0]  ramWrData,
  output logic              ramWrEn,
  output logic              statusFlag
);
  logic [NIB_W-1:0]  aQ, bQ, yQ, immQ;
  logic [ADDR_W-1:0] ptrQ, dirQ;
  logic [NIB_W-1:0]  lhsVal, rhsVal, bitMask;
  logic [NIB_W:0]    diff;
  logic              neRes, leRes, isWrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aQ <= '0; bQ <= '0; yQ <= '0; immQ <= '0;
      ptrQ <= '0; dirQ <= '0;
    end else if (strobes.latchEn) begin
      aQ <= regA; bQ <= regB; yQ <= regY; immQ <= immField;
      ptrQ <= ramPtr; dirQ <= directAddr;
    end
  end

  assign ramAddr = strobes.useDirect ? dirQ : ptrQ;

  always_comb begin
    case (strobes.lhsSel)
      L_A:     lhsVal = aQ;
      L_B:     lhsVal = bQ;
      L_Y:     lhsVal = yQ;
      default: lhsVal = immQ;
    endcase
  end

  assign rhsVal = strobes.rhsMem ? ramRdData : immQ;
  assign diff   = {1'b0, rhsVal} - {1'b0, lhsVal};
  assign neRes  = (lhsVal != rhsVal);
  assign leRes  = ~diff[NIB_W];

  genvar gi;
  generate
    for (gi = 0; gi < NIB_W; gi++) begin : g_mask
      assign bitMask[gi] = (immQ[BIT_W-1:0] == BIT_W'(gi));
    end
  endgenerate

  assign isWrite   = (strobes.kind == K_SET) || (strobes.kind == K_CLR);
  assign ramWrEn   = strobes.execEn && isWrite;
  assign ramWrData = (strobes.kind == K_SET) ? (ramRdData | bitMask)
                                             : (ramRdData & ~bitMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusFlag <= 1'b0;
    end else if (strobes.execEn) begin
      case (strobes.kind)
        K_NE:    statusFlag <= neRes;
        K_LE:    statusFlag <= leRes;
        K_TEST:  statusFlag <= ramRdData[immQ[BIT_W-1:0]];
        default: statusFlag <= statusFlag;
      endcase
    end
  end

  // R4
  keep_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrEn |-> (((ramWrData ^ ramRdData) & ~bitMask) == '0));

  // R4
  write_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrEn |=> $stable(statusFlag));

  // R6
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.execEn |=> $stable(statusFlag));
endmodule

// File: rtl/nibble_cmp_unit.sv
module nibble_cmp_unit
  import nibcmp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [9:0]        instrWord,
  input  logic              hasSecond,
  input  logic [ADDR_W-1:0] directAddr,
  input  logic [3:0]        regA,
  input  logic [3:0]        regB,
  input  logic [3:0]        regY,
  input  logic [ADDR_W-1:0] ramPtr,
  output logic [ADDR_W-1:0] ramAddr,
  input  logic [3:0]        ramRdData,
  output logic [3:0]        ramWrData,
  output logic              ramWrEn,
  output logic              statusFlag,
  output logic [1:0]        cycleCount,
  output logic              execPulse
);
  ctrl_t strobes;

  nibcmp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .instrWord  (instrWord),
    .hasSecond  (hasSecond),
    .strobes    (strobes),
    .cycleCount (cycleCount)
  );

  nibcmp_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .immField   (instrWord[NIB_W-1:0]),
    .directAddr (directAddr),
    .regA       (regA),
    .regB       (regB),
    .regY       (regY),
    .ramPtr     (ramPtr),
    .ramRdData  (ramRdData),
    .ramAddr    (ramAddr),
    .ramWrData  (ramWrData),
    .ramWrEn    (ramWrEn),
    .statusFlag (statusFlag)
  );

  assign execPulse = strobes.execEn;

  // R11
  nop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (execPulse && strobes.kind == K_NOP) |-> !ramWrEn);
endmodule

// File: tb/nibble_cmp_unit_tb.sv
module nibble_cmp_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] instrWord = '0;
  logic       hasSecond = 1'b0;
  logic [3:0] directAddr = '0;
  logic [3:0] regA = '0, regB = '0, regY = '0;
  logic [3:0] ramPtr = '0;
  logic [3:0] ramAddr, ramRdData, ramWrData;
  logic       ramWrEn, statusFlag, execPulse;
  logic [1:0] cycleCount;

  logic [3:0] mem [16];
  int nChecks = 0;
  int nFails  = 0;
  logic expStatus = 1'b0;

  always #10 clk = ~clk;

  nibble_cmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instrWord(instrWord),
    .hasSecond(hasSecond), .directAddr(directAddr), .regA(regA), .regB(regB),
    .regY(regY), .ramPtr(ramPtr), .ramAddr(ramAddr), .ramRdData(ramRdData),
    .ramWrData(ramWrData), .ramWrEn(ramWrEn), .statusFlag(statusFlag),
    .cycleCount(cycleCount), .execPulse(execPulse)
  );

  assign ramRdData = mem[ramAddr];
  always @(posedge clk) if (ramWrEn) mem[ramAddr] <= ramWrData;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference decode from the requirement encodings
  // kind: 0 none, 1 ne, 2 le, 3 set, 4 clr, 5 test; lhs: 0 A,1 B,2 Y,3 imm
  task automatic refDecode(input logic [9:0] w, output int kind, output int lhs,
                           output bit rhsMem, output bit dirOk);
    kind = 0; lhs = 0; rhsMem = 1; dirOk = 0;
    if (w == 10'b0000000100)            begin kind = 1; dirOk = 1; end
    else if (w == 10'b0001000100)       begin kind = 1; lhs = 1; end
    else if (w[9:4] == 6'b000010)       begin kind = 1; lhs = 3; dirOk = 1; end
    else if (w[9:4] == 6'b000111)       begin kind = 1; lhs = 2; rhsMem = 0; end
    else if (w == 10'b0000010100)       begin kind = 2; dirOk = 1; end
    else if (w == 10'b0011000100)       begin kind = 2; lhs = 1; end
    else if (w[9:4] == 6'b000011)       begin kind = 2; lhs = 3; dirOk = 1; end
    else if (w[9:4] == 6'b101011)       begin kind = 2; rhsMem = 0; end
    else if (w[9:2] == 8'b00100001)     begin kind = 3; dirOk = 1; end
    else if (w[9:2] == 8'b00100010)     begin kind = 4; dirOk = 1; end
    else if (w[9:2] == 8'b00100011)     begin kind = 5; dirOk = 1; end
  endtask

  task automatic runOp(input logic [9:0] w, input bit hs, input logic [3:0] da,
                       input logic [3:0] a, input logic [3:0] b, input logic [3:0] y,
                       input logic [3:0] ptr);
    int kind, lhs; bit rhsMem, dirOk, useDir, expWr;
    logic [3:0] addr, m, lv, rv, expMem;
    string req;
    refDecode(w, kind, lhs, rhsMem, dirOk);
    useDir = hs && dirOk;
    addr = useDir ? da : ptr;
    m = mem[addr];
    lv = (lhs == 0) ? a : (lhs == 1) ? b : (lhs == 2) ? y : w[3:0];
    rv = rhsMem ? m : w[3:0];
    expWr = (kind == 3 || kind == 4);
    expMem = m;
    case (kind)
      1: begin expStatus = (lv != rv); req = "R2"; end
      2: begin expStatus = (lv <= rv); req = "R3"; end
      3: begin expMem[w[1:0]] = 1'b1; req = "R4"; end
      4: begin expMem[w[1:0]] = 1'b0; req = "R4"; end
      5: begin expStatus = m[w[1:0]]; req = "R5"; end
      default: req = "R11";
    endcase
    instrWord = w; hasSecond = hs; directAddr = da;
    regA = a; regB = b; regY = y; ramPtr = ptr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R12: scramble sampled inputs after acceptance
    regA = ~a; regB = ~b; regY = ~y; ramPtr = ~ptr; directAddr = ~da;
    instrWord = $urandom;
    chk(cycleCount == (useDir ? 2'd2 : 2'd1), (hs && !dirOk) ? "R8" : "R9",
        cycleCount, useDir ? 2 : 1);
    if (useDir) begin
      chk(execPulse == 1'b0, "R7", execPulse, 0);
      @(negedge clk);
    end
    chk(execPulse == 1'b1, "R6", execPulse, 1);
    chk(ramAddr == addr, useDir ? "R7" : (hs ? "R8" : "R6"), ramAddr, addr);
    chk(ramWrEn == expWr, req, ramWrEn, expWr);
    // R10: a start during execution must be dropped
    start = 1'b1; instrWord = 10'b0000000100;
    @(negedge clk);
    start = 1'b0;
    chk(execPulse == 1'b0, "R10", execPulse, 0);
    chk(statusFlag == expStatus, {req, " R12"}, statusFlag, expStatus);
    chk(mem[addr] == expMem, {req, " R12"}, mem[addr], expMem);
  endtask

  function automatic logic [9:0] randWord();
    logic [3:0] f = 4'($urandom_range(0, 11));
    logic [3:0] i = 4'($urandom);
    case (f)
      0: return 10'b0000000100;
      1: return 10'b0001000100;
      2: return {6'b000010, i};
      3: return {6'b000111, i};
      4: return 10'b0000010100;
      5: return 10'b0011000100;
      6: return {6'b000011, i};
      7: return {6'b101011, i};
      8: return {8'b00100001, i[1:0]};
      9: return {8'b00100010, i[1:0]};
      10: return {8'b00100011, i[1:0]};
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 16; k++) mem[k] = 4'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(statusFlag == 0 && ramWrEn == 0 && execPulse == 0, "R1", statusFlag, 0);
    chk(cycleCount == 0, "R1", cycleCount, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(execPulse == 0 && cycleCount == 0 && statusFlag == 0, "R1", cycleCount, 0);

    // directed corners
    mem[5] = 4'h7;
    runOp(10'b0000000100, 0, 0, 4'h7, 0, 0, 4'd5);         // R2 equal -> 0
    runOp(10'b0000000100, 0, 0, 4'h6, 0, 0, 4'd5);         // R2 differ -> 1
    runOp(10'b0001000100, 1, 4'd9, 0, 4'h7, 0, 4'd5);      // R8 B form
    runOp({6'b000111, 4'hA}, 0, 0, 0, 0, 4'hA, 4'd0);      // R2 Y vs imm
    runOp(10'b0000010100, 0, 0, 4'h7, 0, 0, 4'd5);         // R3 equal -> 1
    mem[0] = 4'h0;
    runOp(10'b0000010100, 0, 0, 4'hF, 0, 0, 4'd0);         // R3 F vs 0 -> 0
    runOp({6'b101011, 4'h0}, 1, 4'd3, 4'h0, 0, 0, 4'd0);   // R3/R8 0<=0
    runOp({6'b000011, 4'hF}, 0, 0, 0, 0, 0, 4'd0);         // R3 F<=0 -> 0
    mem[12] = 4'h0;
    runOp({8'b00100001, 2'd3}, 1, 4'd12, 0, 0, 0, 4'd1);   // R4/R7 set bit 3
    mem[13] = 4'hF;
    runOp({8'b00100010, 2'd0}, 0, 0, 0, 0, 0, 4'd13);      // R4 clear bit 0
    for (int n = 0; n < 4; n++)
      runOp({8'b00100011, 2'(n)}, 1, 4'd12, 0, 0, 0, 4'd2); // R5 test each bit
    runOp({6'b000010, 4'h8}, 1, 4'd15, 0, 0, 0, 4'd0);     // R7 direct immediate
    runOp(10'h3FF, 1, 4'd2, 0, 0, 0, 4'd4);                // R11 no match

    for (int t = 0; t < 400; t++)
      runOp(randWord(), 1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
            4'($urandom), 4'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule